// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block timestamps external events. It has two independent capture channels. Each channel takes an asynchronous event pin and brings it into the peripheral clock domain with a two-flop synchroniser. It then looks for a transition of the kind selected by that channel's 2-bit mode field. When it finds one, it copies the 16-bit timer value supplied on an input port into that channel's capture register and sets a sticky flag.

An interrupt line is raised whenever a flagged channel also has its enable bit set. The unit can therefore also serve as a pair of edge-triggered interrupt sources with a programmable edge polarity. The counter that produces the timer value and the register decoding around the block live elsewhere.

No stream interface is involved. Captured values are held in registers that are always readable, so there is no back-pressure. A later capture simply replaces the earlier value, whether or not it has been read.

Top module: `edge_capture_unit`

## Requirements
- R1: An event pin is recognised through two synchronising flops. A transition applied before clock edge k updates that channel's capture register and flag at clock edge k+2.
- R2: A high or low level held for a single clock period is recognised as a transition.
- R3: Mode code 01 captures on rising transitions of the synchronised pin only.
- R4: Mode code 10 captures on falling transitions only.
- R5: Mode code 11 captures on both rising and falling transitions.
- R6: Mode code 00 disables the channel. Its capture register and flag do not change, whatever the pin does.
- R7: The captured value is the `timer_val` present during the clock period that ends at the capturing edge.
- R8: A channel's flag stays set until a clear pulse on that channel's bit of `flag_clr`. The flag is low after the edge at which the clear is sampled.
- R9: When a capture and a clear for the same channel fall at the same edge, the flag ends up set.
- R10: A new capture overwrites the capture register even while the flag is still set.
- R11: `irq` is the OR, over both channels, of the flag ANDed with that channel's `irq_en` bit. It follows `irq_en` without a clock delay.
- R12: While `rst_n` is low, all capture registers, flags and synchroniser stages are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 16 | Current timer count to be captured |
| evt_pin | input | 2 | Asynchronous event pins; bit i belongs to channel i |
| edge_mode | input | 4 | Mode per channel; bits [2i+1:2i] for channel i: 00 off, 01 rising, 10 falling, 11 both |
| irq_en | input | 2 | Interrupt enable per channel |
| flag_clr | input | 2 | Clear pulse for each channel's flag |
| cap_val | output | 32 | Capture registers; bits [16i+15:16i] for channel i |
| cap_flag | output | 2 | Sticky capture flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench goes after single-period pulses. A design that compared the wrong synchroniser stages would drop these pulses or report them one clock late. It checks clears that coincide with captures, where a design giving priority to the clear would lose the event. It captures a second time while the flag is still up, where a design that blocked that capture would keep a stale timestamp. It also switches a channel to disabled mode while its pin is toggling and toggles the enable bits over set flags, which exposes designs that leak captures or register the interrupt.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/ecu_sync.sv
module ecu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ecu_edge_detect.sv
module ecu_edge_detect
  import ecu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  logic [1:0] mode,
  output logic       hit
);
  logic       prev_q;
  logic       rise, fall;
  edge_mode_e m;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
  assign m    = edge_mode_e'(mode);

  always_comb begin
    unique case (m)
      EDGE_OFF:  hit = 1'b0;
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  // a detection always corresponds to a change of the sampled level
  assert_hit_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ($past(level) != $past(prev_q)));
  // disabled mode never reports an edge
  assert_off_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !hit);
endmodule

// File: rtl/ecu_channel.sv
module ecu_channel #(
  parameter int TW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic [1:0]    mode,
  input  logic [TW-1:0] timer_val,
  input  logic          clr,
  output logic [TW-1:0] cap_q,
  output logic          flag_q
);
  logic pin_s;
  logic hit;

  ecu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
  );

  ecu_edge_detect u_det (
    .clk(clk), .rst_n(rst_n), .level(pin_s), .mode(mode), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   cap_q <= '0;
    else if (hit) cap_q <= timer_val;

  // capture has priority over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    flag_q <= 1'b0;
    else if (hit)  flag_q <= 1'b1;
    else if (clr)  flag_q <= 1'b0;

  assert_cap_takes_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cap_q == $past(timer_val)));
  assert_cap_holds_without_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cap_q));
  assert_hit_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr) |=> flag_q);
  assert_flag_falls_only_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr));
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int NCH = 2,
  parameter int TW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     timer_val,
  input  logic [NCH-1:0]    evt_pin,
  input  logic [2*NCH-1:0]  edge_mode,
  input  logic [NCH-1:0]    irq_en,
  input  logic [NCH-1:0]    flag_clr,
  output logic [NCH*TW-1:0] cap_val,
  output logic [NCH-1:0]    cap_flag,
  output logic              irq
);
  localparam int MW = 2;

  generate
    genvar c;
    for (c = 0; c < NCH; c++) begin : g_ch
      ecu_channel #(.TW(TW), .SYNC_STAGES(SYNC_STAGES)) u_ch (
        .clk(clk),
        .rst_n(rst_n),
        .pin(evt_pin[c]),
        .mode(edge_mode[c*MW +: MW]),
        .timer_val(timer_val),
        .clr(flag_clr[c]),
        .cap_q(cap_val[c*TW +: TW]),
        .flag_q(cap_flag[c])
      );
    end
  endgenerate

  assign irq = |(cap_flag & irq_en);

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_flag & irq_en) == '0) |-> !irq);
endmodule

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timer_val = '0;
  logic [1:0]  evt_pin = '0;
  logic [3:0]  edge_mode = '0;
  logic [1:0]  irq_en = '0;
  logic [1:0]  flag_clr = '0;
  logic [31:0] cap_val;
  logic [1:0]  cap_flag;
  logic        irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference state
  logic [1:0]  m_s1 = '0, m_s2 = '0, m_prev = '0;
  logic [15:0] m_cap [2];
  logic [1:0]  m_flag = '0;

  always #2.5 clk = ~clk;

  edge_capture_unit i_edge_capture_unit (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .evt_pin(evt_pin),
    .edge_mode(edge_mode), .irq_en(irq_en), .flag_clr(flag_clr),
    .cap_val(cap_val), .cap_flag(cap_flag), .irq(irq)
  );

  function automatic logic edge_hit(input logic [1:0] mode, input logic now, input logic was);
    case (mode)
      2'b01:   return now & ~was;
      2'b10:   return ~now & was;
      2'b11:   return now ^ was;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "cap0", {16'h0, cap_val[15:0]},  {16'h0, m_cap[0]});
    check(tag, "cap1", {16'h0, cap_val[31:16]}, {16'h0, m_cap[1]});
    check(tag, "flag", {30'h0, cap_flag}, {30'h0, m_flag});
    check("R11", "irq", {31'h0, irq}, {31'h0, |(m_flag & irq_en)});
  endtask

  task automatic step(input logic [1:0] pin, input logic [3:0] mode, input logic [1:0] en,
                      input logic [1:0] clr, input string tag);
    logic [1:0] hit;
    @(negedge clk);
    compare(tag);
    evt_pin   = pin;
    edge_mode = mode;
    irq_en    = en;
    flag_clr  = clr;
    timer_val = 16'($urandom);
    @(posedge clk);
    #1;
    for (int c = 0; c < 2; c++) begin
      hit[c] = edge_hit(mode[2*c +: 2], m_s2[c], m_prev[c]);
      if (hit[c]) m_cap[c] = timer_val;
      if (hit[c])      m_flag[c] = 1'b1;
      else if (clr[c]) m_flag[c] = 1'b0;
    end
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = pin;
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h1234_5EED);
    m_cap[0] = '0;
    m_cap[1] = '0;
    evt_pin = 2'b11;
    repeat (3) @(posedge clk);
    // R12: reset state with pins held high
    @(negedge clk);
    compare("R12");
    evt_pin = 2'b00;
    rst_n = 1'b1;

    // R3: rising only, R1 latency covered by per-step comparison
    for (int i = 0; i < 4; i++) step(2'b11, 4'b0101, 2'b11, 2'b00, "R3");
    for (int i = 0; i < 4; i++) step(2'b00, 4'b0101, 2'b11, 2'b00, "R3");
    step(2'b00, 4'b0101, 2'b11, 2'b11, "R8");
    for (int i = 0; i < 3; i++) step(2'b00, 4'b0101, 2'b11, 2'b00, "R8");
    // R4: falling only
    for (int i = 0; i < 4; i++) step(2'b11, 4'b1010, 2'b01, 2'b00, "R4");
    for (int i = 0; i < 4; i++) step(2'b00, 4'b1010, 2'b01, 2'b00, "R4");
    // R2: single-period pulses with both-edge mode
    step(2'b01, 4'b1111, 2'b10, 2'b11, "R2");
    step(2'b10, 4'b1111, 2'b10, 2'b00, "R2");
    step(2'b00, 4'b1111, 2'b10, 2'b00, "R2");
    for (int i = 0; i < 4; i++) step(2'b00, 4'b1111, 2'b10, 2'b00, "R5");
    // R10: overwrite while flag is still set
    step(2'b11, 4'b1111, 2'b11, 2'b00, "R10");
    for (int i = 0; i < 4; i++) step(2'b11, 4'b1111, 2'b11, 2'b00, "R10");
    // R9: clear in the same cycle as a capture
    step(2'b00, 4'b1111, 2'b11, 2'b00, "R9");
    step(2'b00, 4'b1111, 2'b11, 2'b00, "R9");
    step(2'b00, 4'b1111, 2'b11, 2'b11, "R9");
    step(2'b00, 4'b1111, 2'b11, 2'b00, "R9");
    step(2'b00, 4'b1111, 2'b11, 2'b11, "R8");
    // R6: disabled channels ignore toggling
    for (int i = 0; i < 12; i++) step(2'(i), 4'b0000, 2'b11, 2'b00, "R6");
    // R11: enable toggling over set flags
    for (int i = 0; i < 4; i++) step(2'b11, 4'b0101, 2'b11, 2'b00, "R11");
    for (int i = 0; i < 4; i++) step(2'b11, 4'b0101, 2'(i), 2'b00, "R11");

    // R7 / R1: constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] p;
      p = evt_pin;
      for (int c = 0; c < 2; c++)
        if (($urandom % 4) == 0) p[c] = ~p[c];
      step(p, 4'($urandom), 2'($urandom),
           (($urandom % 8) == 0) ? 2'($urandom) : 2'b00, "R7");
    end
    @(negedge clk);
    compare("R1");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule